// File: doc/BRIEF.md
# One-Time-Programmable Register Program and Lock Controller

This block holds a one-time-programmable register space and the locking rules that guard it. Register 0 is 128 bits wide and is split into a lower and an upper 64-bit half. Sixteen more 128-bit registers follow it. Two 16-bit lock words decide which segments can still be written. A lock bit protects a segment while it reads 0. Every cell, lock bits included, uses flash rules: a program operation stores the AND of the old word and the new word, so a bit can go from 1 to 0 but never back.

A client issues one 16-bit program request with a word address. The block decodes the address into one of four targets: lock word 0, lock word 1, a data word, or nothing. It then commits the data or raises sticky error flags in the status byte. After each accepted request, a ready flag stays low for a fixed number of cycles. A combinational read port returns any data word or lock word. An unmapped read address returns zero.

Word address map (defaults): lock word 0 is at 0x80. Register 0 data occupies 0x81..0x88: words 0x81..0x84 form the lower half and 0x85..0x88 the upper half. Lock word 1 is at 0x89. Registers 1..16 occupy 0x8A..0x109, eight consecutive words per register.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After reset, status reads 0x80, lock word 0 reads 0xFFFE, lock word 1 reads 0xFFFF and every data word reads 0xFFFF. Status bit 7 is ready, bit 4 is program error, bit 1 is lock error, and all other status bits are 0.
- R2: An accepted program request to an unlocked data word stores the old word AND the request data.
- R3: A program request whose address decodes to no target changes no stored word and sets status bit 4 only.
- R4: A program request to a data word in a locked segment changes no stored word and sets status bits 4 and 1.
- R5: Bit 0 of lock word 0 stays 0 at all times, so words 0x81..0x84 can never be programmed.
- R6: Clearing bit 1 of lock word 0 (for example by writing 0xFFFD to 0x80) locks words 0x85..0x88.
- R7: Clearing bit n of lock word 1 (at 0x89) locks register n+1, at words 0x8A+8n..0x91+8n. Other registers stay writable.
- R8: A lock bit, once cleared, stays cleared: writing 1s to a lock word never sets a bit.
- R9: After an accepted request, status bit 7 reads 0 for exactly BUSY_CYC cycles. Requests that arrive while it is 0 are ignored and change neither data nor status.
- R10: The error bits are sticky until clr_status is pulsed. If an error is raised in the same cycle as a clear, the error is kept.
- R11: The last mapped word (0x109) is writable, and a read of an unmapped address returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_req | input | 1 | Program request strobe, accepted when ready |
| prog_addr | input | 9 | Word address of the program request |
| prog_data | input | 16 | Data ANDed into the target word |
| clr_status | input | 1 | Clears the sticky error bits |
| rd_addr | input | 9 | Word address of the read port |
| rd_data | output | 16 | Word at rd_addr, or 0 when unmapped |
| status | output | 8 | {ready, 2'b0, program error, 2'b0, lock error, 1'b0} |

## Verification
The bench probes both edges of the address map: 0x7F just below the map, 0x10A just above it, and the lower/upper split inside register 0. An off-by-one decoder would either corrupt a neighbouring register or flag a valid word as out of range. It also tries to set cleared lock bits back by writing 0xFFFF to the lock words. A design that stores instead of ANDing would unlock a register there. It fires a second request inside the busy window. A controller that did not gate on ready would commit that write and, with a bad address, raise an error. It also checks that a locked write sets both error bits. A design that flagged only one of them, or wrote the data anyway, would be exposed by the readback.

// File: rtl/otp_prog_pkg.sv
// Package: shared target encoding for the OTP program controller.
// Assumes: all address maps are word addressed.
package otp_prog_pkg;
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_LOCK0 = 2'd1,
        TGT_LOCK1 = 2'd2,
        TGT_DATA  = 2'd3
    } otp_tgt_e;
endpackage

// File: rtl/otp_addr_decode.sv
// Module: otp_addr_decode
// Maps a word address to a target kind, a flat data-word index and a
// lock segment index (0 = reg0 low half, 1 = reg0 high half, 2+n = reg n+1).
// Assumes WPR is even and the map fits within ADDR_W bits.
module otp_addr_decode
    import otp_prog_pkg::*;
#(
    parameter int unsigned ADDR_W   = 9,
    parameter int unsigned BASE     = 'h80,
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned WPR      = 8,
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned SEG_W    = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output otp_tgt_e          tgt,
    output logic [IDX_W-1:0]  idx,
    output logic [SEG_W-1:0]  seg
);
    localparam int unsigned LOCK1_A = BASE + 1 + WPR;
    localparam int unsigned DATA1_A = LOCK1_A + 1;
    localparam int unsigned LAST_A  = DATA1_A + NUM_REGS * WPR - 1;

    // decode the address into target, word index and segment
    always_comb begin
        int unsigned a;
        int unsigned off;
        a   = int'(addr);
        off = 0;
        tgt = TGT_NONE;
        idx = '0;
        seg = '0;
        if (a == BASE) begin
            tgt = TGT_LOCK0;
        end else if (a == LOCK1_A) begin
            tgt = TGT_LOCK1;
        end else if (a > BASE && a < LOCK1_A) begin
            off = a - BASE - 1;
            tgt = TGT_DATA;
            idx = IDX_W'(off);
            seg = (off >= WPR / 2) ? SEG_W'(1) : SEG_W'(0);
        end else if (a >= DATA1_A && a <= LAST_A) begin
            off = a - DATA1_A;
            tgt = TGT_DATA;
            idx = IDX_W'(WPR + off);
            seg = SEG_W'(2 + off / WPR);
        end
    end
endmodule

// File: rtl/otp_lock_regs.sv
// Module: otp_lock_regs
// Two lock words with flash AND semantics. Bit 0 of word 0 is cleared
// by reset and held cleared. Assumes writes arrive only on accepted requests.
module otp_lock_regs #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we0,
    input  logic          we1,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] lock0,
    output logic [DW-1:0] lock1
);
    localparam logic [DW-1:0] LOCK0_INIT = {{(DW-1){1'b1}}, 1'b0};

    // lock word 0: AND-in writes, keep bit 0 cleared
    always_ff @(posedge clk) begin
        if (!rst_n)   lock0 <= LOCK0_INIT;
        else if (we0) lock0 <= lock0 & wdata & LOCK0_INIT;
    end

    // lock word 1: AND-in writes
    always_ff @(posedge clk) begin
        if (!rst_n)   lock1 <= '1;
        else if (we1) lock1 <= lock1 & wdata;
    end

    // R5
    lock0_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock0[0]);
    // R8
    lock0_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((lock0 & ~$past(lock0)) == '0));
    // R8
    lock1_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((lock1 & ~$past(lock1)) == '0));
endmodule

// File: rtl/otp_word_array.sv
// Module: otp_word_array
// Flat store of OTP data words, all 1s after reset; writes AND into the
// addressed word. One write port and one combinational read port.
module otp_word_array #(
    parameter int unsigned DW      = 16,
    parameter int unsigned N_WORDS = 136,
    parameter int unsigned IDX_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] mem [N_WORDS];

    // erase on reset, AND-program on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(N_WORDS); i++) mem[i] <= '1;
        end else if (we) begin
            mem[widx] <= mem[widx] & wdata;
        end
    end

    // read the indexed word
    assign rdata = mem[ridx];

    // R2
    word_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(widx) < int'(N_WORDS)));
endmodule

// File: rtl/otp_prog_seq.sv
// Module: otp_prog_seq
// Accepts requests when idle, holds ready low for BUSY_CYC cycles after
// each accept, and keeps sticky program/lock error flags.
module otp_prog_seq #(
    parameter int unsigned BUSY_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic clr,
    input  logic bad_range,
    input  logic bad_lock,
    output logic accept,
    output logic ready,
    output logic prog_err,
    output logic lock_err
);
    localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] busy_cnt;

    // requests are taken only while idle
    assign ready  = (busy_cnt == '0);
    assign accept = req && ready;

    // busy countdown
    always_ff @(posedge clk) begin
        if (!rst_n)             busy_cnt <= '0;
        else if (accept)        busy_cnt <= CNT_W'(BUSY_CYC);
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1'b1;
    end

    // sticky error flags; a new error wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_err <= 1'b0;
            lock_err <= 1'b0;
        end else begin
            prog_err <= (prog_err && !clr) || (accept && (bad_range || bad_lock));
            lock_err <= (lock_err && !clr) || (accept && bad_lock);
        end
    end

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready);
    // R10
    prog_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_err && !clr) |=> prog_err);
    // R4
    lock_implies_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |-> prog_err);
endmodule

// File: rtl/otp_prog_ctrl.sv
// Module: otp_prog_ctrl (top)
// OTP program and lock controller: decodes program and read addresses,
// applies the segment locks, commits data or flags errors.
// Assumes NUM_REGS fits in one lock word (NUM_REGS <= DW).
module otp_prog_ctrl
    import otp_prog_pkg::*;
#(
    parameter int unsigned DW       = 16,
    parameter int unsigned ADDR_W   = 9,
    parameter int unsigned BASE     = 'h80,
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned WPR      = 8,
    parameter int unsigned BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DW-1:0]     prog_data,
    input  logic              clr_status,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic [7:0]        status
);
    localparam int unsigned N_WORDS = WPR * (NUM_REGS + 1);
    localparam int unsigned IDX_W   = $clog2(N_WORDS);
    localparam int unsigned N_SEG   = NUM_REGS + 2;
    localparam int unsigned SEG_W   = $clog2(N_SEG);

    otp_tgt_e         p_tgt, r_tgt;
    logic [IDX_W-1:0] p_idx, r_idx;
    logic [SEG_W-1:0] p_seg, r_seg;
    logic [DW-1:0]    lock0, lock1, word_rd;
    logic [N_SEG-1:0] seg_open;
    logic             accept, ready, prog_err, lock_err;
    logic             bad_range, bad_lock, mem_we;

    // program-side address decode
    otp_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .NUM_REGS(NUM_REGS),
                      .WPR(WPR), .IDX_W(IDX_W), .SEG_W(SEG_W))
        u_pdec (.addr(prog_addr), .tgt(p_tgt), .idx(p_idx), .seg(p_seg));

    // read-side address decode
    otp_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .NUM_REGS(NUM_REGS),
                      .WPR(WPR), .IDX_W(IDX_W), .SEG_W(SEG_W))
        u_rdec (.addr(rd_addr), .tgt(r_tgt), .idx(r_idx), .seg(r_seg));

    // segment is writable while its lock bit is still 1
    assign seg_open  = {lock1[NUM_REGS-1:0], lock0[1:0]};
    assign bad_range = (p_tgt == TGT_NONE);
    assign bad_lock  = (p_tgt == TGT_DATA) && !seg_open[p_seg];
    assign mem_we    = accept && (p_tgt == TGT_DATA) && seg_open[p_seg];

    otp_prog_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(prog_req), .clr(clr_status),
        .bad_range(bad_range), .bad_lock(bad_lock), .accept(accept),
        .ready(ready), .prog_err(prog_err), .lock_err(lock_err)
    );

    otp_lock_regs #(.DW(DW)) u_locks (
        .clk(clk), .rst_n(rst_n),
        .we0(accept && (p_tgt == TGT_LOCK0)),
        .we1(accept && (p_tgt == TGT_LOCK1)),
        .wdata(prog_data), .lock0(lock0), .lock1(lock1)
    );

    otp_word_array #(.DW(DW), .N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_words (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .widx(p_idx),
        .wdata(prog_data), .ridx(r_idx), .rdata(word_rd)
    );

    // read mux by decoded target
    always_comb begin
        unique case (r_tgt)
            TGT_LOCK0: rd_data = lock0;
            TGT_LOCK1: rd_data = lock1;
            TGT_DATA:  rd_data = word_rd;
            default:   rd_data = '0;
        endcase
    end

    // status byte assembly
    assign status = {ready, 2'b00, prog_err, 2'b00, lock_err, 1'b0};

    // R3
    range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bad_range) |=> (status[4] && !mem_we_q));
    // R4
    lock_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bad_lock) |=> (status[4] && status[1]));
    // R4
    no_locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (p_seg > SEG_W'(0)));

    logic mem_we_q;
    // R3: registered write strobe used only by the checks above
    always_ff @(posedge clk) begin
        if (!rst_n) mem_we_q <= 1'b0;
        else        mem_we_q <= mem_we;
    end
endmodule

// File: tb/otp_prog_ctrl_test.sv
// Bench: directed scenarios for otp_prog_ctrl, one task per scenario.
module otp_prog_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_req = 1'b0;
    logic [8:0]  prog_addr = '0;
    logic [15:0] prog_data = '0;
    logic        clr_status = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    otp_prog_ctrl uut (
        .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_addr(prog_addr),
        .prog_data(prog_data), .clr_status(clr_status), .rd_addr(rd_addr),
        .rd_data(rd_data), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [8:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    // one request pulse at a negedge, then wait until ready again
    task automatic prog(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        prog_addr = a; prog_data = d; prog_req = 1'b1;
        @(negedge clk);
        prog_req = 1'b0;
        repeat (BUSY) @(negedge clk);
    endtask

    task automatic clear_st();
        @(negedge clk);
        clr_status = 1'b1;
        @(negedge clk);
        clr_status = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status", {8'h0, status}, 16'h0080);
        read_chk("R1 lock0", 9'h080, 16'hFFFE);
        read_chk("R1 lock1", 9'h089, 16'hFFFF);
        read_chk("R1 data", 9'h085, 16'hFFFF);
    endtask

    task automatic t_program();
        prog(9'h085, 16'h12F0);
        read_chk("R2 write", 9'h085, 16'h12F0);
        prog(9'h085, 16'hFF0F);
        read_chk("R2 AND", 9'h085, 16'h1200);
        check("R2 status", {8'h0, status}, 16'h0080);
    endtask

    task automatic t_low_half();
        prog(9'h081, 16'h0000);
        read_chk("R5 data kept", 9'h081, 16'hFFFF);
        check("R4 R5 status", {8'h0, status}, 16'h0092);
        clear_st();
        check("R10 clear", {8'h0, status}, 16'h0080);
    endtask

    task automatic t_range();
        prog(9'h07F, 16'h0000);
        check("R3 below", {8'h0, status}, 16'h0090);
        read_chk("R3 neighbour", 9'h081, 16'hFFFF);
        prog(9'h10A, 16'h0000);
        check("R3 above", {8'h0, status}, 16'h0090);
        read_chk("R3 last kept", 9'h109, 16'hFFFF);
        read_chk("R11 unmapped read", 9'h10A, 16'h0000);
        // R10: error raised while clear pulses is kept
        @(negedge clk);
        prog_addr = 9'h07F; prog_req = 1'b1; clr_status = 1'b1;
        @(negedge clk);
        prog_req = 1'b0; clr_status = 1'b0;
        check("R10 set wins", {8'h0, status[4], 7'h0}, 16'h0080);
        repeat (BUSY) @(negedge clk);
        clear_st();
    endtask

    task automatic t_busy();
        @(negedge clk);
        prog_addr = 9'h08A; prog_data = 16'h00FF; prog_req = 1'b1;
        @(negedge clk);
        prog_addr = 9'h090; prog_data = 16'h0000;
        for (int i = 0; i < BUSY; i++) begin
            check("R9 busy", {15'h0, status[7]}, 16'h0000);
            @(negedge clk);
            if (i == 0) prog_addr = 9'h07F;
        end
        prog_req = 1'b0;
        check("R9 ready back", {8'h0, status}, 16'h0080);
        read_chk("R9 first taken", 9'h08A, 16'h00FF);
        read_chk("R9 second ignored", 9'h090, 16'hFFFF);
    endtask

    task automatic t_lock1();
        prog(9'h089, 16'hFFFB);
        read_chk("R7 lock1", 9'h089, 16'hFFFB);
        prog(9'h09A, 16'h0000);
        check("R7 locked status", {8'h0, status}, 16'h0092);
        read_chk("R7 locked data", 9'h09A, 16'hFFFF);
        clear_st();
        prog(9'h099, 16'h5555);
        read_chk("R7 neighbour", 9'h099, 16'h5555);
        check("R7 neighbour status", {8'h0, status}, 16'h0080);
        prog(9'h089, 16'hFFFF);
        read_chk("R8 lock1 kept", 9'h089, 16'hFFFB);
    endtask

    task automatic t_lock0();
        prog(9'h080, 16'hFFFD);
        read_chk("R6 lock0", 9'h080, 16'hFFFC);
        prog(9'h086, 16'h0000);
        check("R6 status", {8'h0, status}, 16'h0092);
        read_chk("R6 data kept", 9'h086, 16'hFFFF);
        clear_st();
        prog(9'h080, 16'hFFFF);
        read_chk("R8 lock0 kept", 9'h080, 16'hFFFC);
    endtask

    task automatic t_last();
        prog(9'h109, 16'hA5A5);
        read_chk("R11 last word", 9'h109, 16'hA5A5);
        check("R11 status", {8'h0, status}, 16'h0080);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_low_half();
        t_range();
        t_busy();
        t_lock1();
        t_lock0();
        t_last();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule